// File: doc/BRIEF.md
# Network Port Activity LED Controller

This block drives a small set of indicator LEDs for an Ethernet port. The inputs are link state and traffic. Each LED has its own 16-bit rule mask. The mask chooses which conditions light the LED steadily: a link speed, a duplex mode, or recent transmit or receive activity. It also chooses which conditions make the LED flash: transmit, receive or collision activity, or a link speed. Each LED also has a 16-bit override register. When the override is enabled, the rules are ignored and the LED is held off, held on, or made to follow one of two externally generated blink waveforms. A single polarity bit, shared by all LEDs, sets whether a lit LED drives its pin high or low.

Activity arrives as single-cycle pulses. A pulse on transmit, receive or collision reloads a per-source stretch counter. The counter is sized by a parameter so that activity stays visible for a human-scale window (10 ms at the default clock).

All configuration is reached through a plain 16-bit address, write-strobe and read-data port. Decoding of the serial management protocol that feeds this port lives outside the block. So does generation of the two blink waveforms.

Top module: `net_led_ctrl`

## Requirements
- R1: LED n (n = 0..2) has its rule mask at address 0x8078 − 2n and its override register at 0x8079 − 2n. The polarity register is at 0x901A. A write to these addresses updates the register on the next clock edge, and the same address reads it back on `reg_rdata` combinationally. A write to any other address changes no register and no LED, and a read of any other address returns 0.
- R2: After reset every rule mask, every override register and the polarity bit are zero, and every `led_out` pin is high (unlit).
- R3: Bit 6 of the polarity register is the only stored bit of that register and applies to all LEDs. When it is 0 a lit LED drives its pin low. When it is 1 a lit LED drives its pin high.
- R4: Override bit 15 set makes bits 14:13 decide the LED: 0 = off, 1 = on, 2 = follow `blink2`, 3 = follow `blink1`. With bit 15 clear, bits 14:13 have no effect and the rule mask decides.
- R5: Steady rule bits light the LED while their condition holds. Bit 4 = 10M, bit 5 = 100M, bit 6 = 1000M, bit 15 = 2500M, bit 12 = full duplex, bit 11 = half duplex. `link_speed` encodes 0 = 10M, 1 = 100M, 2 = 1000M, 3 = 2500M. `full_duplex` = 1 means full duplex.
- R6: While `link_up` is 0, every speed and duplex condition is false.
- R7: A pulse on `tx_pulse`, `rx_pulse` or `col_pulse` keeps that source active for STRETCH_CYCLES clock cycles, counted from the edge that samples the pulse. Rule bit 8 lights the LED while transmit is active. Rule bit 7 lights it while receive is active.
- R8: Activity blink bits are bit 10 (transmit), bit 9 (receive) and bit 3 (collision). Each requests blinking on `blink1` while its source is active. The request counts only if some enabled speed or duplex steady bit (15, 12, 11, 6, 5, 4) currently holds, or if bypass bit 13 is set.
- R9: While any blink request is present the LED follows `blink1` even if a steady condition also holds.
- R10: Speed blink bits are bit 0 (10M), bit 1 (100M), bit 2 (1000M) and bit 14 (2500M). Each requests blinking on `blink1` while the link is up at that speed, with no activity needed.
- R11: An all-zero rule mask with the override disabled leaves the LED unlit.
- R12: A new pulse while a source is still active restarts its full STRETCH_CYCLES window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10M, 1 = 100M, 2 = 1000M, 3 = 2500M |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_pulse | input | 1 | One-cycle transmit activity event |
| rx_pulse | input | 1 | One-cycle receive activity event |
| col_pulse | input | 1 | One-cycle collision event |
| blink1 | input | 1 | External blink waveform, channel 1 |
| blink2 | input | 1 | External blink waveform, channel 2 |
| led_out | output | NUM_LEDS | LED pins after polarity |

## Verification
The bench targets the stretch window edges. It checks that the LED is still lit on the last active cycle and dark one cycle later, and that a second pulse pushes the dark cycle out. An off-by-one counter, or one that ignores the retrigger, would shift the dark cycle. It separates a blink request without qualification, which must stay dark, from the same request with bypass or a matching speed, which must follow `blink1`. A design that did not gate activity blinking would light the LED, and one that ORed blink with steady would stay lit while `blink1` is low. It also checks that link-down masks speed and duplex bits, that override mode bits do nothing without the enable bit, and that the polarity bit flips every pin at once.

// File: rtl/net_led_ctrl.sv
module net_led_ctrl #(
  parameter int          NUM_LEDS       = 3,
  parameter int          STRETCH_CYCLES = 1000000,
  parameter logic [15:0] PAT_BASE       = 16'h8078,
  parameter logic [15:0] POL_ADDR       = 16'h901A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [15:0]         reg_addr,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  input  logic                link_up,
  input  logic [1:0]          link_speed,
  input  logic                full_duplex,
  input  logic                tx_pulse,
  input  logic                rx_pulse,
  input  logic                col_pulse,
  input  logic                blink1,
  input  logic                blink2,
  output logic [NUM_LEDS-1:0] led_out
);

  localparam int          CW        = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD  = CW'(STRETCH_CYCLES);
  localparam logic [15:0] QUAL_MASK = 16'h9870;

  logic [15:0]   pat_q [NUM_LEDS];
  logic [15:0]   frc_q [NUM_LEDS];
  logic          pol_q;
  logic [CW-1:0] act_cnt [3];
  logic [2:0]    act_pulse;
  logic [2:0]    act_on;
  logic          s10, s100, s1000, s2500, fd, hd;
  logic [15:0]   stat;

  assign act_pulse = {col_pulse, rx_pulse, tx_pulse};

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_stretch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                act_cnt[k] <= '0;
        else if (act_pulse[k])     act_cnt[k] <= RELOAD;
        else if (act_cnt[k] != '0) act_cnt[k] <= act_cnt[k] - 1'b1;
      end
      assign act_on[k] = (act_cnt[k] != '0);

      // R7
      stretch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_cnt[k] <= RELOAD);
    end
  endgenerate

  assign s10   = link_up && (link_speed == 2'd0);
  assign s100  = link_up && (link_speed == 2'd1);
  assign s1000 = link_up && (link_speed == 2'd2);
  assign s2500 = link_up && (link_speed == 2'd3);
  assign fd    = link_up &&  full_duplex;
  assign hd    = link_up && !full_duplex;

  assign stat = {s2500, 2'b00, fd, hd, 2'b00, act_on[0], act_on[1],
                 s1000, s100, s10, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pol_q <= 1'b0;
    else if (reg_wr && reg_addr == POL_ADDR)  pol_q <= reg_wdata[6];
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (reg_addr == PAT_BASE - 16'(2 * i))         reg_rdata = pat_q[i];
      if (reg_addr == PAT_BASE - 16'(2 * i) + 16'd1) reg_rdata = frc_q[i];
    end
    if (reg_addr == POL_ADDR) reg_rdata = {9'd0, pol_q, 6'd0};
  end

  genvar i;
  generate
    for (i = 0; i < NUM_LEDS; i++) begin : g_led
      localparam logic [15:0] PA = PAT_BASE - 16'(2 * i);
      localparam logic [15:0] FA = PA + 16'd1;

      logic [15:0] p;
      logic steady, qual, act_req, spd_blink, blink_req, rule_lit, frc_lit, lit;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pat_q[i] <= '0;
          frc_q[i] <= '0;
        end else if (reg_wr) begin
          if (reg_addr == PA) pat_q[i] <= reg_wdata;
          if (reg_addr == FA) frc_q[i] <= reg_wdata;
        end
      end

      assign p         = pat_q[i];
      assign steady    = |(p & stat);
      assign qual      = |(p & stat & QUAL_MASK);
      assign act_req   = (p[10] && act_on[0]) || (p[9] && act_on[1]) || (p[3] && act_on[2]);
      assign spd_blink = (p[14] && s2500) || (p[2] && s1000) || (p[1] && s100) || (p[0] && s10);
      assign blink_req = spd_blink || (act_req && (p[13] || qual));
      assign rule_lit  = blink_req ? blink1 : steady;

      always_comb begin
        case (frc_q[i][14:13])
          2'd0:    frc_lit = 1'b0;
          2'd1:    frc_lit = 1'b1;
          2'd2:    frc_lit = blink2;
          default: frc_lit = blink1;
        endcase
      end

      assign lit        = frc_q[i][15] ? frc_lit : rule_lit;
      assign led_out[i] = pol_q ? lit : ~lit;

      // R11
      zero_pat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_q[i][15] && pat_q[i] == 16'd0) |-> (led_out[i] == ~pol_q));
      // R6
      link_down_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !frc_q[i][15] && (pat_q[i] & ~QUAL_MASK) == 16'd0)
          |-> (led_out[i] == ~pol_q));
      // R4
      force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_q[i][15] && frc_q[i][14:13] == 2'd0) |-> (led_out[i] == ~pol_q));
      // R4
      force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_q[i][15] && frc_q[i][14:13] == 2'd1) |-> (led_out[i] == pol_q));
    end
  endgenerate

  // R3
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == POL_ADDR) |=> $stable(pol_q));

endmodule

// File: tb/net_led_ctrl_tb.sv
module net_led_ctrl_tb;
  localparam int STR = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        link_up = 1'b0;
  logic [1:0]  link_speed = '0;
  logic        full_duplex = 1'b0;
  logic        tx_pulse = 1'b0, rx_pulse = 1'b0, col_pulse = 1'b0;
  logic        blink1 = 1'b0, blink2 = 1'b0;
  logic [2:0]  led_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  net_led_ctrl #(.NUM_LEDS(3), .STRETCH_CYCLES(STR)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .link_speed(link_speed), .full_duplex(full_duplex), .tx_pulse(tx_pulse),
    .rx_pulse(rx_pulse), .col_pulse(col_pulse), .blink1(blink1),
    .blink2(blink2), .led_out(led_out));

  // {pattern, link_up, speed, duplex, blink1, expected lit, pad}
  localparam logic [23:0] VEC [17] = '{
    {16'h0010, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'b0},  // R5 10M
    {16'h0010, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'b0},  // R5 wrong speed
    {16'h0020, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 2'b0},  // R5 100M
    {16'h0040, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 2'b0},  // R5 1000M
    {16'h8000, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 2'b0},  // R5 2500M
    {16'h1000, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 2'b0},  // R5 full duplex
    {16'h1000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'b0},  // R5 full bit, half link
    {16'h0800, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'b0},  // R5 half duplex
    {16'h0010, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'b0},  // R6 link down speed
    {16'h1800, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'b0},  // R6 link down duplex
    {16'h0004, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 2'b0},  // R10 blink high
    {16'h0004, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'b0},  // R10 blink low
    {16'h0004, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'b0},  // R10 other speed
    {16'h4000, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 2'b0},  // R10 2500M blink
    {16'h0000, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 2'b0},  // R11 zero mask
    {16'h8004, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 2'b0},  // R9 no request, steady
    {16'hC000, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2'b0}   // R9 blink over steady
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    case (src)
      0: tx_pulse = 1'b1;
      1: rx_pulse = 1'b1;
      default: col_pulse = 1'b1;
    endcase
    @(negedge clk);
    tx_pulse = 1'b0; rx_pulse = 1'b0; col_pulse = 1'b0;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    step(3);
    // R2 reset state
    check("R2 led pins", {13'd0, led_out}, 16'h0007);
    rd(16'h8078, d); check("R2 mask0", d, 16'h0000);
    rd(16'h8075, d); check("R2 override2", d, 16'h0000);
    rd(16'h901A, d); check("R2 polarity", d, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    check("R2 led after release", {13'd0, led_out}, 16'h0007);

    // table walk on LED0
    for (int v = 0; v < 17; v++) begin
      link_up = VEC[v][7]; link_speed = VEC[v][6:5];
      full_duplex = VEC[v][4]; blink1 = VEC[v][3];
      wr(16'h8078, VEC[v][23:8]);
      check($sformatf("R5/R6/R9/R10/R11 vector %0d", v),
            {15'd0, led_out[0]}, {15'd0, ~VEC[v][2]});
    end
    wr(16'h8078, 16'h0000);
    blink1 = 1'b0;

    // R1 register map
    link_up = 1'b1; link_speed = 2'd0; full_duplex = 1'b0;
    wr(16'h8076, 16'h0010);
    rd(16'h8076, d); check("R1 mask1 readback", d, 16'h0010);
    wr(16'h807A, 16'hFFFF);
    rd(16'h807A, d); check("R1 unmapped read", d, 16'h0000);
    rd(16'h8078, d); check("R1 mask0 untouched", d, 16'h0000);
    rd(16'h8079, d); check("R1 override0 untouched", d, 16'h0000);
    check("R1 leds after stray write", {13'd0, led_out}, 16'h0005);
    wr(16'h8076, 16'h0000);

    // R4 override on LED2
    wr(16'h8074, 16'h0010);
    check("R4 rule lit", {15'd0, led_out[2]}, 16'h0000);
    wr(16'h8075, 16'h8000);
    check("R4 forced off", {15'd0, led_out[2]}, 16'h0001);
    wr(16'h8075, 16'hA000);
    check("R4 forced on", {15'd0, led_out[2]}, 16'h0000);
    wr(16'h8075, 16'hC000);
    blink2 = 1'b1; blink1 = 1'b0; #1;
    check("R4 blink2 high", {15'd0, led_out[2]}, 16'h0000);
    blink2 = 1'b0; #1;
    check("R4 blink2 low", {15'd0, led_out[2]}, 16'h0001);
    wr(16'h8075, 16'hE000);
    blink1 = 1'b1; #1;
    check("R4 blink1 high", {15'd0, led_out[2]}, 16'h0000);
    blink1 = 1'b0; #1;
    check("R4 blink1 low", {15'd0, led_out[2]}, 16'h0001);
    wr(16'h8075, 16'h6000);
    check("R4 mode bits without enable", {15'd0, led_out[2]}, 16'h0000);

    // R3 polarity
    wr(16'h8075, 16'hA000);
    wr(16'h8074, 16'h0000);
    wr(16'h901A, 16'h0040);
    rd(16'h901A, d); check("R3 polarity readback", d, 16'h0040);
    check("R3 active high pins", {13'd0, led_out}, 16'h0004);
    wr(16'h901A, 16'hFFBF);
    rd(16'h901A, d); check("R3 only bit 6 stored", d, 16'h0000);
    check("R3 active low pins", {13'd0, led_out}, 16'h0003);
    wr(16'h8075, 16'h0000);

    // R7 transmit stretch
    wr(16'h8078, 16'h0100);
    pulse(0);
    check("R7 tx first cycle", {15'd0, led_out[0]}, 16'h0000);
    step(STR - 1);
    check("R7 tx last cycle", {15'd0, led_out[0]}, 16'h0000);
    step(1);
    check("R7 tx expired", {15'd0, led_out[0]}, 16'h0001);
    // R7 receive stretch
    wr(16'h8078, 16'h0080);
    pulse(1);
    check("R7 rx active", {15'd0, led_out[0]}, 16'h0000);
    step(STR);
    check("R7 rx expired", {15'd0, led_out[0]}, 16'h0001);

    // R12 retrigger
    wr(16'h8078, 16'h0100);
    pulse(0);
    step(9);
    pulse(0);
    step(14);
    check("R12 retrigger extends", {15'd0, led_out[0]}, 16'h0000);
    step(STR - 15);
    check("R12 last cycle after retrigger", {15'd0, led_out[0]}, 16'h0000);
    step(1);
    check("R12 expired after retrigger", {15'd0, led_out[0]}, 16'h0001);

    // R8 qualification and bypass
    link_speed = 2'd1;
    wr(16'h8078, 16'h0410);
    pulse(0);
    blink1 = 1'b1; #1;
    check("R8 unqualified stays dark", {15'd0, led_out[0]}, 16'h0001);
    wr(16'h8078, 16'h2410);
    check("R8 bypass blink high", {15'd0, led_out[0]}, 16'h0000);
    blink1 = 1'b0; #1;
    check("R8 bypass blink low", {15'd0, led_out[0]}, 16'h0001);
    wr(16'h8078, 16'h0410);
    link_speed = 2'd0; #1;
    check("R9 qualified blink low over steady", {15'd0, led_out[0]}, 16'h0001);
    blink1 = 1'b1; #1;
    check("R8 qualified blink high", {15'd0, led_out[0]}, 16'h0000);
    step(STR + 2);
    blink1 = 1'b0; #1;
    check("R8 steady after activity ends", {15'd0, led_out[0]}, 16'h0000);
    wr(16'h8078, 16'h2008);
    pulse(2);
    blink1 = 1'b1; #1;
    check("R8 collision blink high", {15'd0, led_out[0]}, 16'h0000);
    blink1 = 1'b0; #1;
    check("R8 collision blink low", {15'd0, led_out[0]}, 16'h0001);

    finish_run();
  end
endmodule